// File: doc/BRIEF.md
# Four-Channel Counter/Timer

This block holds four independent count-down channels behind one byte-wide write port. Each channel runs either as a timer, stepping its 8-bit down counter once every 16 or 256 system clocks through a prescaler, or as an event counter, stepping once per rising edge on its own trigger input. When a channel's counter runs out it reloads itself from its stored constant, pulses its zero-count output for one clock and, if enabled, latches an interrupt request.

Software sets a channel up with a control byte. One control bit announces that a time constant comes next; the following write to that channel becomes the constant, loads the counter and starts it. Another control bit halts the channel until a fresh constant arrives. A write with bit 0 clear, made while no constant is due, stores the channel's interrupt vector. Pending requests from the four channels are ranked with channel 0 highest; the winner's number and vector are presented at the top, and an acknowledge clears the winner.

Top module: `ctc4`

## Requirements
- R1: After reset every counter reads 0, no channel counts, `zc_out` is 0 and `irq_any` is 0.
- R2: A write with bit 0 = 0 while no constant is due stores `{wr_data[7:1],1'b0}` as that channel's vector; `irq_vec` shows the vector of the channel named by `irq_id`.
- R3: A control write (bit 0 = 1) with bit 2 = 1 makes the next write to that channel the time constant; that write loads the counter (readable in the following cycle) and starts counting. Before it, the channel does not count.
- R4: In timer mode (control bit 6 = 0) the counter steps down once per 16 clocks when control bit 5 = 0 and once per 256 clocks when bit 5 = 1; the first zero-count pulse appears exactly constant x divisor clocks after the load.
- R5: In counter mode (control bit 6 = 1) the counter steps down once per rising edge of the channel's `trig_in` bit; with constant 1 every rising edge gives a zero-count pulse and an interrupt request, visible in the cycle after the edge.
- R6: When the counter would reach zero it reloads the constant and `zc_out` is high for exactly one clock; successive pulses are spaced by the same period.
- R7: A constant of 0 counts as 256.
- R8: Control bit 7 enables the interrupt request; with it clear, zero-count pulses still occur but no request is latched.
- R9: A control write with bit 1 = 1 halts the channel: its counter holds its value and no pulse occurs until a new constant is loaded via R3.
- R10: Among pending requests the lowest channel number wins on `irq_id`; `irq_ack` clears the request of the current winner.
- R11: `rd_data` shows, without delay, the current counter value of the channel selected by `rd_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Channel addressed by the write |
| wr_data | input | 8 | Control byte, constant or vector |
| trig_in | input | 4 | Per-channel event inputs for counter mode |
| rd_sel | input | 2 | Channel whose counter is read |
| rd_data | output | 8 | Counter value of `rd_sel` |
| zc_out | output | 4 | One-clock zero-count pulses |
| irq_ack | input | 1 | Clears the winning request |
| irq_any | output | 1 | At least one request pending |
| irq_id | output | 2 | Winning channel number |
| irq_vec | output | 8 | Vector of the winning channel |

## Verification
On every cycle the embedded properties check that a zero-count pulse lasts one clock and coincides with the counter holding its constant, that a step lowers the counter by exactly one, that a halted channel keeps its value, that a request only rises with its enable set, and that the winner is the lowest pending channel. The exact periods for both divisors, the constant-0 case, the order in which requests are served, the vector contents and the absence of counting before a constant or after a halt are shown only by the bench's timed scenarios.

// File: rtl/ctc_pkg.sv
package ctc_pkg;
  // control-byte bit positions
  localparam int B_CTL  = 0;
  localparam int B_HALT = 1;
  localparam int B_FOLW = 2;
  localparam int B_BIG  = 5;
  localparam int B_CNT  = 6;
  localparam int B_IE   = 7;

  typedef struct packed {
    logic ie;
    logic cnt_mode;
    logic pre_big;
  } chan_cfg_t;

  function automatic logic [7:0] vec_from(input logic [7:0] d);
    return {d[7:1], 1'b0};
  endfunction

  function automatic chan_cfg_t cfg_from(input logic [7:0] d);
    chan_cfg_t c;
    c.ie       = d[B_IE];
    c.cnt_mode = d[B_CNT];
    c.pre_big  = d[B_BIG];
    return c;
  endfunction
endpackage

// File: rtl/ctc_prescaler.sv
module ctc_prescaler #(
  parameter int LO_LOG = 4,
  parameter int HI_LOG = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  input  logic big,
  output logic tick
);
  localparam int PW = HI_LOG;
  localparam logic [PW-1:0] LIM_LO = PW'((1 << LO_LOG) - 1);
  localparam logic [PW-1:0] LIM_HI = {PW{1'b1}};

  logic [PW-1:0] pre;
  logic [PW-1:0] lim;

  assign lim  = big ? LIM_HI : LIM_LO;
  assign tick = run && !clear && (pre == lim);

  always_ff @(posedge clk) begin
    if (!rst_n || clear || !run) pre <= '0;
    else if (pre == lim)         pre <= '0;
    else                         pre <= pre + 1'b1;
  end
endmodule

// File: rtl/ctc_downcnt.sv
module ctc_downcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] cnt,
  output logic         hit,
  output logic         zc
);
  assign hit = tick && !load && (cnt == W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      zc  <= 1'b0;
    end else begin
      zc <= hit;
      if (load)      cnt <= load_val;
      else if (hit)  cnt <= reload_val;
      else if (tick) cnt <= cnt - 1'b1;
    end
  end

  // R6
  zc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zc |=> !zc);
  // R6
  zc_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zc |-> (cnt == reload_val));
  // R4
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !hit) |=> (cnt == $past(cnt) - W'(1)));
endmodule

// File: rtl/ctc_chan.sv
module ctc_chan
  import ctc_pkg::*;
#(
  parameter int W      = 8,
  parameter int LO_LOG = 4,
  parameter int HI_LOG = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         trig,
  input  logic         ack,
  output logic [W-1:0] cnt,
  output logic         zc,
  output logic         pend,
  output logic [W-1:0] vec
);
  chan_cfg_t   cfg;
  logic [W-1:0] tconst;
  logic        await_tc;
  logic        running;
  logic        trig_q;
  logic        edge_evt;
  logic        pre_tick;
  logic        step;
  logic        load_evt;
  logic        hit;

  assign load_evt = we && await_tc;
  assign edge_evt = trig && !trig_q;
  assign step     = running && (cfg.cnt_mode ? edge_evt : pre_tick);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg      <= '0;
      tconst   <= '0;
      await_tc <= 1'b0;
      running  <= 1'b0;
      vec      <= '0;
      trig_q   <= 1'b0;
    end else begin
      trig_q <= trig;
      if (we) begin
        if (await_tc) begin
          tconst   <= wdata;
          await_tc <= 1'b0;
          running  <= 1'b1;
        end else if (wdata[B_CTL]) begin
          cfg <= cfg_from(wdata);
          if (wdata[B_HALT]) running  <= 1'b0;
          if (wdata[B_FOLW]) await_tc <= 1'b1;
        end else begin
          vec <= vec_from(wdata);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              pend <= 1'b0;
    else if (hit && cfg.ie)  pend <= 1'b1;
    else if (ack)            pend <= 1'b0;
  end

  ctc_prescaler #(.LO_LOG(LO_LOG), .HI_LOG(HI_LOG)) u_pre (
    .clk(clk), .rst_n(rst_n),
    .run(running && !cfg.cnt_mode),
    .clear(load_evt),
    .big(cfg.pre_big),
    .tick(pre_tick)
  );

  ctc_downcnt #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .load(load_evt), .load_val(wdata),
    .tick(step), .reload_val(tconst),
    .cnt(cnt), .hit(hit), .zc(zc)
  );

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !load_evt) |=> $stable(cnt));
  // R8
  irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(cfg.ie));
endmodule

// File: rtl/ctc4.sv
module ctc4
  import ctc_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int W      = 8,
  parameter int LO_LOG = 4,
  parameter int HI_LOG = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [$clog2(N_CH)-1:0] wr_sel,
  input  logic [W-1:0]            wr_data,
  input  logic [N_CH-1:0]         trig_in,
  input  logic [$clog2(N_CH)-1:0] rd_sel,
  output logic [W-1:0]            rd_data,
  output logic [N_CH-1:0]         zc_out,
  input  logic                    irq_ack,
  output logic                    irq_any,
  output logic [$clog2(N_CH)-1:0] irq_id,
  output logic [W-1:0]            irq_vec
);
  localparam int SW = $clog2(N_CH);

  logic [W-1:0]    cnt_a [N_CH];
  logic [W-1:0]    vec_a [N_CH];
  logic [N_CH-1:0] pend;
  logic [N_CH-1:0] ack_v;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    assign ack_v[i] = irq_ack && irq_any && (irq_id == SW'(i));
    ctc_chan #(.W(W), .LO_LOG(LO_LOG), .HI_LOG(HI_LOG)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .we(wr_en && (wr_sel == SW'(i))),
      .wdata(wr_data),
      .trig(trig_in[i]),
      .ack(ack_v[i]),
      .cnt(cnt_a[i]),
      .zc(zc_out[i]),
      .pend(pend[i]),
      .vec(vec_a[i])
    );
  end

  always_comb begin
    irq_id = '0;
    for (int i = N_CH - 1; i >= 0; i--)
      if (pend[i]) irq_id = SW'(i);
  end

  assign irq_any = |pend;
  assign irq_vec = vec_a[irq_id];
  assign rd_data = cnt_a[rd_sel];

  // R10
  prio_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any |-> (pend[irq_id] &&
      ($countones(pend & ((N_CH'(1) << irq_id) - N_CH'(1))) == 0)));
endmodule

// File: tb/test_ctc4.sv
module test_ctc4;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] trig_in = '0;
  logic [1:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic [3:0] zc_out;
  logic       irq_ack = 1'b0;
  logic       irq_any;
  logic [1:0] irq_id;
  logic [7:0] irq_vec;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] seen_zc;
  logic       seen_irq;

  localparam logic [7:0] K_CTL = 8'h01, K_HALT = 8'h02, K_FOLW = 8'h04,
                         K_BIG = 8'h20, K_CNT = 8'h40, K_IE = 8'h80;

  always #4 clk = ~clk;

  ctc4 i_ctc4 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .trig_in(trig_in), .rd_sel(rd_sel), .rd_data(rd_data), .zc_out(zc_out),
    .irq_ack(irq_ack), .irq_any(irq_any), .irq_id(irq_id), .irq_vec(irq_vec)
  );

  function automatic int period_of(input int tc, input bit big);
    int eff = (tc == 0) ? 256 : tc;
    return eff * (big ? 256 : 16);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = 2'(ch); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] m);
    trig_in = m;
    @(negedge clk);
    seen_zc = zc_out; seen_irq = irq_any;
    trig_in = '0;
    @(negedge clk);
  endtask

  task automatic ack();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic wait_zc(input int ch, input int limit, output int k);
    k = 0;
    while (k < limit) begin
      @(negedge clk);
      k++;
      if (zc_out[ch]) break;
    end
  endtask

  task automatic rd(input int ch, output int v);
    rd_sel = 2'(ch);
    #1;
    v = int'(rd_data);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int k, v, tc, ch, p;
    bit big, any_zc;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rd(i, v);
      chk(v == 0, "R1 counter", v, 0);
    end
    chk(zc_out == 0 && !irq_any, "R1 outputs", int'({zc_out, irq_any}), 0);

    // R3 nothing counts until the constant arrives
    wr(0, K_IE | K_FOLW | K_CTL);
    any_zc = 0;
    repeat (40) begin @(negedge clk); if (zc_out[0]) any_zc = 1; end
    rd(0, v);
    chk(!any_zc && v == 0, "R3 idle before constant", v, 0);
    wr(0, 8'd2);
    rd(0, v);
    chk(v == 2, "R3 load visible", v, 2);
    wait_zc(0, 200, k);
    chk(k == period_of(2, 0), "R3/R4 first period", k, period_of(2, 0));
    chk(irq_any && irq_id == 0, "R8 request with enable", int'(irq_id), 0);

    // R9 halt keeps value, no pulses
    wr(0, K_HALT | K_CTL);
    rd(0, v);
    any_zc = 0;
    repeat (50) begin @(negedge clk); if (zc_out[0]) any_zc = 1; end
    rd(0, p);
    chk(p == v && !any_zc, "R9 halted hold", p, v);
    ack();
    chk(!irq_any, "R10 ack clears", int'(irq_any), 0);
    wr(0, K_IE | K_FOLW | K_HALT | K_CTL);
    wr(0, 8'd1);
    wait_zc(0, 100, k);
    chk(k == 16, "R9 restart after new constant", k, 16);
    wr(0, K_HALT | K_CTL);
    ack();

    // R4/R6 random timer trials
    for (int t = 0; t < 6; t++) begin
      ch  = int'($urandom % 4);
      big = 1'($urandom % 2);
      tc  = big ? 1 + int'($urandom % 3) : 1 + int'($urandom % 12);
      wr(ch, K_IE | K_FOLW | K_HALT | K_CTL | (big ? K_BIG : 8'h00));
      wr(ch, 8'(tc));
      wait_zc(ch, 2000, k);
      chk(k == period_of(tc, big), "R4 period", k, period_of(tc, big));
      chk(irq_any && irq_id == 2'(ch), "R8 random request", int'(irq_id), ch);
      rd(ch, v);
      chk(v == tc, "R6 reload value", v, tc);
      @(negedge clk);
      chk(zc_out[ch] == 1'b0, "R6 one-clock pulse", int'(zc_out[ch]), 0);
      wait_zc(ch, 2000, k);
      chk(k == period_of(tc, big) - 1, "R6 repeat period", k + 1, period_of(tc, big));
      wr(ch, K_HALT | K_CTL);
      ack();
    end

    // R7 constant 0 means 256
    wr(1, K_IE | K_FOLW | K_HALT | K_CTL);
    wr(1, 8'd0);
    wait_zc(1, 5000, k);
    chk(k == period_of(0, 0), "R7 constant zero", k, period_of(0, 0));
    wr(1, K_HALT | K_CTL);
    ack();

    // R5/R11 counter mode
    wr(2, K_IE | K_CNT | K_FOLW | K_HALT | K_CTL);
    wr(2, 8'd5);
    pulse(4'b0100); pulse(4'b0100);
    rd(2, v);
    chk(v == 3, "R11 readback after two edges", v, 3);
    pulse(4'b0100); pulse(4'b0100);
    chk(seen_zc[2] == 1'b0, "R5 no early pulse", int'(seen_zc[2]), 0);
    pulse(4'b0100);
    chk(seen_zc[2] && seen_irq, "R5 fifth edge pulses", int'(seen_zc[2]), 1);
    rd(2, v);
    chk(v == 5, "R6 counter-mode reload", v, 5);
    // R2 vector of channel 2
    wr(2, 8'hA6);
    chk(irq_id == 2 && irq_vec == 8'hA6, "R2 vector out", int'(irq_vec), 8'hA6);
    ack();

    // R5 constant 1: every edge
    wr(2, K_IE | K_CNT | K_FOLW | K_HALT | K_CTL);
    wr(2, 8'd1);
    for (int e = 0; e < 3; e++) begin
      pulse(4'b0100);
      chk(seen_zc[2] && seen_irq, "R5 per-edge request", int'(seen_zc[2]), 1);
      ack();
    end

    // R8 enable clear: pulse but no request
    wr(3, K_CNT | K_FOLW | K_HALT | K_CTL);
    wr(3, 8'd1);
    pulse(4'b1000);
    chk(seen_zc[3] && !seen_irq, "R8 masked request", int'(seen_irq), 0);

    // R10 priority ordering
    for (int i = 0; i < 4; i++) begin
      wr(i, K_IE | K_CNT | K_FOLW | K_HALT | K_CTL);
      wr(i, 8'd1);
    end
    pulse(4'b1110);
    chk(irq_any && irq_id == 1, "R10 first winner", int'(irq_id), 1);
    ack();
    chk(irq_any && irq_id == 2, "R10 second winner", int'(irq_id), 2);
    ack();
    chk(irq_any && irq_id == 3, "R10 third winner", int'(irq_id), 3);
    ack();
    chk(!irq_any, "R10 all served", int'(irq_any), 0);
    pulse(4'b1001);
    chk(irq_id == 0, "R10 channel 0 first", int'(irq_id), 0);
    ack();
    chk(irq_id == 3, "R10 then channel 3", int'(irq_id), 3);
    ack();

    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule